// File: doc/BRIEF.md
# Gated Programmable Clock Divider

This block makes a peripheral clock from one parent clock. A small register port sets the division ratio and a run/stop gate. The ratio comes from a divisor field that is 5 bits wide, or 6 bits wide when the `WIDE_FIELD` parameter is set. The field encoding is not linear. A field value of zero selects the largest ratio. In the wide configuration, the top field bit adds a fixed divide-by-64 stage in front of the lower five bits.

A divisor write is not applied straight away. The new ratio waits until the output period in progress has finished, so the output never carries a shortened pulse. While a ratio update is waiting, two busy flags in the status register stay high. Software polls these flags before and after each divisor write. Divisor writes that arrive while busy is high are dropped. The run/stop gate also takes effect only at a period boundary. In the ratio-1 pass-through path, the gate goes through a latch that is open while the parent clock is low.

Register map: address 0 is the divisor field, in the low bits. Address 1 is the run gate, in bit 0. Address 2 is status, with busy in bits 3 and 4.

Top module: `gcd_top`

## Requirements
- R1: A field value k with 1 <= k <= 31 and the prescale bit (field bit 5, wide configuration only) clear divides the parent clock by k. In the narrow configuration, bit 5 of a written value is masked off.
- R2: A field value of 0 divides by the field mask plus one: 32 in the narrow configuration and 64 in the wide one.
- R3: In the wide configuration, with field bit 5 set, the ratio is 64 times field bits [4:0]. If those low bits are zero, the ratio falls back to 64.
- R4: For a ratio N >= 2, each output period lasts N parent cycles. It starts with floor(N/2) cycles high, and the rest of the period is low. For N = 1, the output follows the parent clock.
- R5: Clearing bit 0 at address 1 stops the output low from the next period boundary. Setting it restarts the output at the next boundary. Address 1 reads back the written bit.
- R6: An accepted divisor write sets status bits 3 and 4 (address 2) on the next cycle. Both bits stay set until the new ratio is handed over, and then both clear.
- R7: A divisor write made while busy is set is ignored. Address 0 keeps returning the pending value, and that value is the one applied.
- R8: A new ratio is taken up only at the end of the output period in progress. That period completes with the old ratio.
- R9: After reset, the run gate reads 1, the field reads 0 (maximum ratio), busy is clear, and the first periods use the maximum ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe, one parent cycle |
| regAddr | input | 2 | Register address (0 divisor, 1 gate, 2 status) |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for `regAddr`, combinational |
| clkOut | output | 1 | Divided, gated clock |

## Verification
The collision this block has to handle is a divisor write, or a second write, arriving at the same time as a period boundary of the running ratio. The bench provokes it by writing in the middle of a long period and then writing again at once while busy is set. It judges the result at the output: the time between rising edges must equal the old ratio exactly once, and then the new ratio. The read-back must show that the second write was dropped. Gate changes are placed in the middle of periods in the same way, and the result is judged by counting output rising edges across fixed windows.

// File: rtl/gcd_pkg.sv
package gcd_pkg;

  localparam int FIELD_MAX_W = 6;
  localparam int RATIO_W     = 11;   // holds 64*31 = 1984
  localparam int PRESCALE    = 64;

  localparam logic [1:0] ADDR_DIV  = 2'd0;
  localparam logic [1:0] ADDR_EN   = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  localparam int BUSY_LO_BIT = 3;
  localparam int BUSY_HI_BIT = 4;

  typedef struct packed {
    logic                   swapReq;
    logic [FIELD_MAX_W-1:0] field;
    logic                   enReq;
  } ctrl_strobe_t;

  function automatic logic [RATIO_W-1:0] decodeRatio(
      input logic [FIELD_MAX_W-1:0] f, input logic wide);
    logic [RATIO_W-1:0] r;
    if (wide && f[5])
      r = RATIO_W'(f[4:0]) * RATIO_W'(PRESCALE);
    else
      r = RATIO_W'(f[4:0]);
    if (r == '0)
      r = wide ? RATIO_W'(64) : RATIO_W'(32);
    return r;
  endfunction

endpackage

// File: rtl/gcd_ctrl.sv
module gcd_ctrl
  import gcd_pkg::*;
#(
  parameter bit WIDE_FIELD = 1'b1,
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              takeUp,
  output ctrl_strobe_t      strobe,
  output logic              busy,
  output logic [FIELD_MAX_W-1:0] fieldOut
);

  localparam int FIELD_W = WIDE_FIELD ? 6 : 5;
  localparam logic [FIELD_MAX_W-1:0] FIELD_MASK = FIELD_MAX_W'((1 << FIELD_W) - 1);

  logic [FIELD_MAX_W-1:0] fieldQ;
  logic                   busyQ;
  logic                   enQ;
  logic                   divWrite;
  logic                   enWrite;

  assign divWrite = regWrEn && (regAddr == ADDR_W'(ADDR_DIV));
  assign enWrite  = regWrEn && (regAddr == ADDR_W'(ADDR_EN));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fieldQ <= '0;
      busyQ  <= 1'b0;
      enQ    <= 1'b1;
    end else begin
      if (divWrite && !busyQ) begin
        fieldQ <= regWrData[FIELD_MAX_W-1:0] & FIELD_MASK;
        busyQ  <= 1'b1;
      end else if (takeUp) begin
        busyQ  <= 1'b0;
      end
      if (enWrite)
        enQ <= regWrData[0];
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_W'(ADDR_DIV):  regRdData[FIELD_MAX_W-1:0] = fieldQ;
      ADDR_W'(ADDR_EN):   regRdData[0] = enQ;
      ADDR_W'(ADDR_STAT): begin
        regRdData[BUSY_LO_BIT] = busyQ;
        regRdData[BUSY_HI_BIT] = busyQ;
      end
      default: regRdData = '0;
    endcase
  end

  assign strobe.swapReq = busyQ;
  assign strobe.field   = fieldQ;
  assign strobe.enReq   = enQ;
  assign busy           = busyQ;
  assign fieldOut       = fieldQ;

endmodule

// File: rtl/gcd_clkpath.sv
module gcd_clkpath
  import gcd_pkg::*;
#(
  parameter bit WIDE_FIELD = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_strobe_t       strobe,
  output logic               takeUp,
  output logic [RATIO_W-1:0] cnt,
  output logic [RATIO_W-1:0] ratio,
  output logic               clkOut
);

  localparam logic [RATIO_W-1:0] RESET_RATIO = decodeRatio('0, WIDE_FIELD);

  logic [RATIO_W-1:0] ratioQ, ratioNext;
  logic [RATIO_W-1:0] cntQ, cntNext;
  logic [RATIO_W-1:0] halfNext;
  logic               enActQ, enNext;
  logic               divQ;
  logic               enLatQ;
  logic               periodEnd;

  assign periodEnd = (cntQ >= ratioQ - 1'b1);
  assign takeUp    = periodEnd && strobe.swapReq;
  assign ratioNext = takeUp ? decodeRatio(strobe.field, WIDE_FIELD) : ratioQ;
  assign cntNext   = periodEnd ? '0 : cntQ + 1'b1;
  assign enNext    = periodEnd ? strobe.enReq : enActQ;
  assign halfNext  = ratioNext >> 1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ratioQ <= RESET_RATIO;
      cntQ   <= RESET_RATIO - 1'b1;
      enActQ <= 1'b1;
      divQ   <= 1'b0;
    end else begin
      ratioQ <= ratioNext;
      cntQ   <= cntNext;
      enActQ <= enNext;
      divQ   <= enNext && (cntNext < halfNext);
    end
  end

  // Gate for the pass-through path, open only while the parent clock is low
  always_latch begin
    if (!clk)
      enLatQ = enActQ;
  end

  assign clkOut = (ratioQ == RATIO_W'(1)) ? (clk & enLatQ) : divQ;
  assign cnt    = cntQ;
  assign ratio  = ratioQ;

endmodule

// File: rtl/gcd_top.sv
module gcd_top
  import gcd_pkg::*;
#(
  parameter bit WIDE_FIELD = 1'b1,
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              clkOut
);

  ctrl_strobe_t           strobe;
  logic                   takeUp;
  logic                   busy;
  logic [FIELD_MAX_W-1:0] field;
  logic [RATIO_W-1:0]     cnt;
  logic [RATIO_W-1:0]     ratio;

  gcd_ctrl #(.WIDE_FIELD(WIDE_FIELD), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .takeUp(takeUp),
    .strobe(strobe), .busy(busy), .fieldOut(field)
  );

  gcd_clkpath #(.WIDE_FIELD(WIDE_FIELD)) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .takeUp(takeUp),
    .cnt(cnt), .ratio(ratio), .clkOut(clkOut)
  );

endmodule

// File: rtl/gcd_checker.sv
module gcd_checker
  import gcd_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   regWrEn,
  input logic [ADDR_W-1:0]      regAddr,
  input logic [DATA_W-1:0]      regRdData,
  input logic                   busy,
  input logic                   takeUp,
  input logic [FIELD_MAX_W-1:0] field,
  input logic [RATIO_W-1:0]     cnt,
  input logic [RATIO_W-1:0]     ratio
);

  a_r6_busy_sets: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_W'(ADDR_DIV) && !busy) |=> busy);

  a_r6_busy_holds: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !takeUp) |=> busy);

  a_r6_status_pair: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'(ADDR_STAT)) |->
      (regRdData[BUSY_HI_BIT] == busy && regRdData[BUSY_LO_BIT] == busy));

  a_r7_field_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (busy && regWrEn && regAddr == ADDR_W'(ADDR_DIV)) |=> $stable(field));

  a_r8_ratio_steady: assert property (@(posedge clk) disable iff (!rstN)
    !takeUp |=> $stable(ratio));

  a_r8_swap_at_edge: assert property (@(posedge clk) disable iff (!rstN)
    takeUp |=> (cnt == '0));

  a_r4_cnt_range: assert property (@(posedge clk) disable iff (!rstN)
    cnt < ratio);

endmodule

bind gcd_top gcd_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .regRdData(regRdData), .busy(busy), .takeUp(takeUp), .field(field),
  .cnt(cnt), .ratio(ratio)
);

// File: tb/tb_gcd_top.sv
module tb_gcd_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWrData = 8'd0;
  logic [7:0] rdW, rdN;
  logic       clkW, clkN;

  int checks = 0;
  int errors = 0;
  int risesW = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gcd_top #(.WIDE_FIELD(1'b1)) dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(rdW), .clkOut(clkW));

  gcd_top #(.WIDE_FIELD(1'b0)) dutN (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(rdN), .clkOut(clkN));

  always @(posedge clkW) risesW++;

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int expRatio(input int f, input bit wide);
    int lo, r;
    lo = f % 32;
    if (wide && f >= 32) r = 64 * lo;
    else r = lo;
    if (r == 0) r = wide ? 64 : 32;
    return r;
  endfunction

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [7:0] dw, output logic [7:0] dn);
    @(negedge clk);
    regAddr = a;
    #1;
    dw = rdW; dn = rdN;
  endtask

  task automatic waitIdle();
    logic [7:0] w, n;
    forever begin
      readReg(2'd2, w, n);
      if (w[4:3] == 2'b00 && n[4:3] == 2'b00) break;
    end
  endtask

  task automatic measure(input bit narrow, output longint per, output longint hi);
    longint r1, tf, r2;
    if (narrow) begin
      @(posedge clkN); r1 = $time; @(negedge clkN); tf = $time; @(posedge clkN); r2 = $time;
    end else begin
      @(posedge clkW); r1 = $time; @(negedge clkW); tf = $time; @(posedge clkW); r2 = $time;
    end
    per = r2 - r1;
    hi  = tf - r1;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] w, n;
    longint per, hi, r0, r1, r2;
    int base;

    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R9 reset state
    readReg(2'd0, w, n); check("R9 field", w, 0);
    readReg(2'd1, w, n); check("R9 gate", w, 1);
    readReg(2'd2, w, n); check("R9 busy", w, 0);
    measure(1'b0, per, hi); check("R9 first period", per, 64 * CLK_PERIOD);

    // Sweep every wide field value: R1, R2, R3, R4
    for (int k = 1; k <= 64; k++) begin
      int f;
      int r;
      f = k % 64;
      r = expRatio(f, 1'b1);
      waitIdle();
      writeReg(2'd0, 8'(f));
      waitIdle();
      measure(1'b0, per, hi);
      if (f == 0) check("R2 period wide zero", per, r * CLK_PERIOD);
      else if (f >= 32) check("R3 period prescaled", per, r * CLK_PERIOD);
      else check("R1 period direct", per, r * CLK_PERIOD);
      if (r == 1) check("R4 pass-through high", hi, CLK_PERIOD / 2);
      else check("R4 high phase", hi, (r / 2) * CLK_PERIOD);
    end

    // R8 and R6: write in the middle of a 64-cycle period
    waitIdle();
    @(posedge clkW); r0 = $time;
    repeat (5) @(negedge clk);
    writeReg(2'd0, 8'd3);
    readReg(2'd2, w, n); check("R6 busy bits set", w[4:3], 2'b11);
    repeat (10) @(negedge clk);
    readReg(2'd2, w, n); check("R6 busy held", w[4:3], 2'b11);
    @(posedge clkW); r1 = $time;
    check("R8 old period completes", r1 - r0, 64 * CLK_PERIOD);
    readReg(2'd2, w, n); check("R6 busy cleared", w[4:3], 2'b00);
    @(posedge clkW); r2 = $time;
    check("R8 new ratio applied", r2 - r1, 3 * CLK_PERIOD);

    // R7: second write while busy is dropped
    waitIdle();
    writeReg(2'd0, 8'd0);
    waitIdle();
    writeReg(2'd0, 8'd5);
    writeReg(2'd0, 8'd9);
    readReg(2'd0, w, n); check("R7 pending kept", w, 5);
    waitIdle();
    measure(1'b0, per, hi); check("R7 pending applied", per, 5 * CLK_PERIOD);

    // R5: gate on divided path (ratio 4)
    writeReg(2'd0, 8'd4);
    waitIdle();
    writeReg(2'd1, 8'd0);
    readReg(2'd1, w, n); check("R5 gate readback", w, 0);
    repeat (20) @(negedge clk);
    base = risesW;
    repeat (50) @(negedge clk);
    check("R5 stopped rises", risesW - base, 0);
    check("R5 stopped level", clkW, 0);
    writeReg(2'd1, 8'd1);
    repeat (20) @(negedge clk);
    base = risesW;
    repeat (40) @(negedge clk);
    check("R5 restarted rises", risesW - base, 10);

    // R5: gate on pass-through path
    writeReg(2'd0, 8'd1);
    waitIdle();
    writeReg(2'd1, 8'd0);
    repeat (5) @(negedge clk);
    base = risesW;
    repeat (30) @(negedge clk);
    check("R5 bypass stopped", risesW - base, 0);
    writeReg(2'd1, 8'd1);
    repeat (5) @(negedge clk);
    base = risesW;
    repeat (30) @(negedge clk);
    check("R5 bypass running", risesW - base, 30);

    // Narrow configuration: R2 and R1 masking
    writeReg(2'd0, 8'd0);
    waitIdle();
    measure(1'b1, per, hi); check("R2 period narrow zero", per, 32 * CLK_PERIOD);
    writeReg(2'd0, 8'h21);
    waitIdle();
    readReg(2'd0, w, n); check("R1 narrow mask readback", n, 1);
    measure(1'b1, per, hi); check("R1 narrow masked period", per, CLK_PERIOD);
    measure(1'b0, per, hi); check("R3 wide 0x21 period", per, 64 * CLK_PERIOD);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule